// File: doc/BRIEF.md
# DMA Channel Interrupt Merger

The block gathers interrupt causes from a bank of DMA channels (16 by default) and turns them into one interrupt request for the processor. Each channel raises three kinds of event: transfer end, transfer start and channel stop. Each event arrives as a one-cycle pulse. The block catches each pulse in its own sticky flag. Software clears a flag by writing a one to it. A write strobe that has already been decoded arrives for each cause as a per-channel vector.

Each cause also has a per-channel enable. A channel's bit in the readable status word is set when at least one of its latched causes is enabled. The status word is reduced to one pending line. That line appears at a fixed bit position (25 by default) of a system-wide pending word, and the other bits of that word stay zero. The pending line is passed to the processor only when the matching bit of the system mask word is one. The latched flags are also brought out as their own vectors. Software can therefore see a cause that was caught while its enable was off.

Top module: `dma_irq_merge`

## Requirements
- R1: While rst_ni is low, and right after it rises, every latched flag, chan_irq_o, sys_pend_o and cpu_irq_o are zero.
- R2: A one on bit n of an event input sets the matching flag on raw_end_o, raw_start_o or raw_stop_o (end, start, stop) at the next rising clock edge. The flag then holds with no further event.
- R3: A one on bit n of a clear input, with no event on that bit, clears that flag at the next edge. Clear bits that are zero leave their flags unchanged.
- R4: When an event and a clear hit the same flag in the same cycle, the flag is set after the edge.
- R5: chan_irq_o[n] is one exactly when at least one of channel n's three flags is set and its enable is one. It follows changes in the enables within the same cycle.
- R6: A cause whose enable is zero is still latched and visible on its raw output, but it does not raise chan_irq_o.
- R7: Bit SYS_BIT (25) of sys_pend_o is one exactly when chan_irq_o is non-zero. All other bits of sys_pend_o are always zero.
- R8: cpu_irq_o is one exactly when sys_pend_o[25] and sys_mask_i[25] are both one. Other mask bits have no effect.
- R9: Channels are independent: an event or clear on one channel changes only that channel's flags and status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_end_i | input | NUM_CH | End-of-transfer event pulses, one per channel |
| evt_start_i | input | NUM_CH | Start-of-transfer event pulses |
| evt_stop_i | input | NUM_CH | Channel-stopped event pulses |
| en_end_i | input | NUM_CH | Per-channel enable of the end cause |
| en_start_i | input | NUM_CH | Per-channel enable of the start cause |
| en_stop_i | input | NUM_CH | Per-channel enable of the stop cause |
| clr_end_i | input | NUM_CH | Write-one-to-clear strobe for end flags |
| clr_start_i | input | NUM_CH | Write-one-to-clear strobe for start flags |
| clr_stop_i | input | NUM_CH | Write-one-to-clear strobe for stop flags |
| sys_mask_i | input | SYS_W | System interrupt mask word |
| raw_end_o | output | NUM_CH | Latched end flags |
| raw_start_o | output | NUM_CH | Latched start flags |
| raw_stop_o | output | NUM_CH | Latched stop flags |
| chan_irq_o | output | NUM_CH | Per-channel interrupt status word |
| sys_pend_o | output | SYS_W | System pending word with the merged line at SYS_BIT |
| cpu_irq_o | output | 1 | Masked interrupt to the processor |

## Verification
Event and clear strobes act on the flags one edge later. The bench drives them on the falling edge and reads the raw flags on the following falling edge, after the single register stage. The status word, the pending word and the processor line depend only on the flags, the enables and the mask, through logic with no registers. The bench checks them 1 ns after driving the inputs, in the same cycle, before the next rising edge can move the flags. Directed steps cover a set and a clear in the same cycle, a cause that is latched while disabled, a mask word with every bit set except bit 25, and a single active channel.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic [1:0] {
    CAUSE_END   = 2'd0,
    CAUSE_START = 2'd1,
    CAUSE_STOP  = 2'd2
  } cause_e;

  localparam int unsigned NUM_CAUSES = 3;
endpackage

// File: rtl/dma_irq_cause_latch.sv
module dma_irq_cause_latch #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  // set beats clear when both land together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/dma_irq_chan_merge.sv
module dma_irq_chan_merge #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               irq_o
);
  assign irq_o = |(flag_i & en_i);
endmodule

// File: rtl/dma_irq_sys_merge.sv
module dma_irq_sys_merge #(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned SYS_W   = 32,
  parameter int unsigned SYS_BIT = 25
) (
  input  logic [NUM_CH-1:0] chan_irq_i,
  input  logic [SYS_W-1:0]  mask_i,
  output logic [SYS_W-1:0]  pend_o,
  output logic              cpu_irq_o
);
  logic any_chan;
  assign any_chan = |chan_irq_i;

  for (genvar b = 0; b < SYS_W; b++) begin : g_pend
    if (b == SYS_BIT) begin : g_live
      assign pend_o[b] = any_chan;
    end else begin : g_zero
      assign pend_o[b] = 1'b0;
    end
  end

  // only SYS_BIT can be non-zero in pend_o
  assign cpu_irq_o = |(pend_o & mask_i);
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned SYS_W   = 32,
  parameter int unsigned SYS_BIT = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_end_i,
  input  logic [NUM_CH-1:0] evt_start_i,
  input  logic [NUM_CH-1:0] evt_stop_i,
  input  logic [NUM_CH-1:0] en_end_i,
  input  logic [NUM_CH-1:0] en_start_i,
  input  logic [NUM_CH-1:0] en_stop_i,
  input  logic [NUM_CH-1:0] clr_end_i,
  input  logic [NUM_CH-1:0] clr_start_i,
  input  logic [NUM_CH-1:0] clr_stop_i,
  input  logic [SYS_W-1:0]  sys_mask_i,
  output logic [NUM_CH-1:0] raw_end_o,
  output logic [NUM_CH-1:0] raw_start_o,
  output logic [NUM_CH-1:0] raw_stop_o,
  output logic [NUM_CH-1:0] chan_irq_o,
  output logic [SYS_W-1:0]  sys_pend_o,
  output logic              cpu_irq_o
);
  localparam int unsigned IDX_END   = int'(CAUSE_END);
  localparam int unsigned IDX_START = int'(CAUSE_START);
  localparam int unsigned IDX_STOP  = int'(CAUSE_STOP);

  logic [NUM_CAUSES-1:0][NUM_CH-1:0] evt, clr, en, flag;

  assign evt[IDX_END]   = evt_end_i;
  assign evt[IDX_START] = evt_start_i;
  assign evt[IDX_STOP]  = evt_stop_i;
  assign clr[IDX_END]   = clr_end_i;
  assign clr[IDX_START] = clr_start_i;
  assign clr[IDX_STOP]  = clr_stop_i;
  assign en[IDX_END]    = en_end_i;
  assign en[IDX_START]  = en_start_i;
  assign en[IDX_STOP]   = en_stop_i;

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
    dma_irq_cause_latch #(.WIDTH(NUM_CH)) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[c]),
      .clr_i  (clr[c]),
      .q_o    (flag[c])
    );
  end

  assign raw_end_o   = flag[IDX_END];
  assign raw_start_o = flag[IDX_START];
  assign raw_stop_o  = flag[IDX_STOP];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [NUM_CAUSES-1:0] ch_flag, ch_en;
    for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_pick
      assign ch_flag[c] = flag[c][ch];
      assign ch_en[c]   = en[c][ch];
    end
    dma_irq_chan_merge #(.NUM_SRC(NUM_CAUSES)) u_merge (
      .flag_i (ch_flag),
      .en_i   (ch_en),
      .irq_o  (chan_irq_o[ch])
    );
  end

  dma_irq_sys_merge #(
    .NUM_CH  (NUM_CH),
    .SYS_W   (SYS_W),
    .SYS_BIT (SYS_BIT)
  ) u_sys (
    .chan_irq_i (chan_irq_o),
    .mask_i     (sys_mask_i),
    .pend_o     (sys_pend_o),
    .cpu_irq_o  (cpu_irq_o)
  );
endmodule

// File: rtl/dma_irq_merge_chk.sv
module dma_irq_merge_chk #(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned SYS_W   = 32,
  parameter int unsigned SYS_BIT = 25
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] evt_end_i,
  input logic [NUM_CH-1:0] evt_start_i,
  input logic [NUM_CH-1:0] evt_stop_i,
  input logic [NUM_CH-1:0] en_end_i,
  input logic [NUM_CH-1:0] en_start_i,
  input logic [NUM_CH-1:0] en_stop_i,
  input logic [NUM_CH-1:0] clr_end_i,
  input logic [NUM_CH-1:0] clr_start_i,
  input logic [NUM_CH-1:0] clr_stop_i,
  input logic [SYS_W-1:0]  sys_mask_i,
  input logic [NUM_CH-1:0] raw_end_o,
  input logic [NUM_CH-1:0] raw_start_o,
  input logic [NUM_CH-1:0] raw_stop_o,
  input logic [NUM_CH-1:0] chan_irq_o,
  input logic [SYS_W-1:0]  sys_pend_o,
  input logic              cpu_irq_o
);
  localparam int unsigned AW = 3 * NUM_CH;
  localparam logic [SYS_W-1:0] LIVE = SYS_W'(1) << SYS_BIT;

  logic [AW-1:0] evt_all, clr_all, raw_all, en_all, both_all, clr_only;
  assign evt_all  = {evt_stop_i, evt_start_i, evt_end_i};
  assign clr_all  = {clr_stop_i, clr_start_i, clr_end_i};
  assign raw_all  = {raw_stop_o, raw_start_o, raw_end_o};
  assign en_all   = {en_stop_i, en_start_i, en_end_i};
  assign both_all = evt_all & clr_all;
  assign clr_only = clr_all & ~evt_all;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_all) |=> ((raw_all & $past(evt_all)) == $past(evt_all)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_all == '0 && clr_all == '0) |=> $stable(raw_all));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_only) |=> ((raw_all & $past(clr_only)) == '0));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|both_all) |=> ((raw_all & $past(both_all)) == $past(both_all)));

  p_disabled_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_all == '0) |-> (chan_irq_o == '0));

  p_idle_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_irq_o == '0) |-> (sys_pend_o == '0));

  p_fixed_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_pend_o & ~LIVE) == '0);

  p_mask_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> (sys_pend_o[SYS_BIT] && sys_mask_i[SYS_BIT]));
endmodule

bind dma_irq_merge dma_irq_merge_chk #(
  .NUM_CH  (NUM_CH),
  .SYS_W   (SYS_W),
  .SYS_BIT (SYS_BIT)
) u_chk (.*);

// File: tb/dma_irq_merge_tb_top.sv
module dma_irq_merge_tb_top;
  localparam int unsigned NCH = 16;
  localparam int unsigned SW  = 32;
  localparam int unsigned SB  = 25;
  localparam int unsigned MAX_CYC = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [NCH-1:0] ev [3];
  logic [NCH-1:0] cl [3];
  logic [NCH-1:0] en [3];
  logic [SW-1:0]  mask;
  logic [NCH-1:0] raw_e, raw_s, raw_p, chan_irq;
  logic [SW-1:0]  pend;
  logic           cpu_irq;

  logic [NCH-1:0] m [3];
  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  dma_irq_merge #(.NUM_CH(NCH), .SYS_W(SW), .SYS_BIT(SB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_end_i(ev[0]), .evt_start_i(ev[1]), .evt_stop_i(ev[2]),
    .en_end_i(en[0]), .en_start_i(en[1]), .en_stop_i(en[2]),
    .clr_end_i(cl[0]), .clr_start_i(cl[1]), .clr_stop_i(cl[2]),
    .sys_mask_i(mask),
    .raw_end_o(raw_e), .raw_start_o(raw_s), .raw_stop_o(raw_p),
    .chan_irq_o(chan_irq), .sys_pend_o(pend), .cpu_irq_o(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] exp_stat();
    logic [NCH-1:0] r;
    r = (m[0] & en[0]) | (m[1] & en[1]) | (m[2] & en[2]);
    return r;
  endfunction

  task automatic idle();
    for (int c = 0; c < 3; c++) begin
      ev[c] = '0;
      cl[c] = '0;
    end
  endtask

  // inputs already driven after a falling edge
  task automatic step();
    logic [NCH-1:0] st;
    #1;
    st = exp_stat();
    chk("R5 R6 status word", 32'(chan_irq), 32'(st));
    chk("R7 pending word", pend, (st != '0) ? (32'd1 << SB) : 32'd0);
    chk("R8 cpu line", 32'(cpu_irq), 32'((st != '0) && mask[SB]));
    @(posedge clk);
    for (int c = 0; c < 3; c++) m[c] = ev[c] | (m[c] & ~cl[c]);
    @(negedge clk);
    chk("R2 R3 R4 end flags", 32'(raw_e), 32'(m[0]));
    chk("R2 R3 R4 start flags", 32'(raw_s), 32'(m[1]));
    chk("R2 R3 R4 stop flags", 32'(raw_p), 32'(m[2]));
  endtask

  initial begin
    #(MAX_CYC * 20);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    for (int c = 0; c < 3; c++) begin
      en[c] = '0;
      m[c]  = '0;
    end
    mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 raw end", 32'(raw_e), 32'd0);
    chk("R1 raw start", 32'(raw_s), 32'd0);
    chk("R1 raw stop", 32'(raw_p), 32'd0);
    chk("R1 status", 32'(chan_irq), 32'd0);
    chk("R1 pending", pend, 32'd0);
    chk("R1 cpu", 32'(cpu_irq), 32'd0);
    rst_ni = 1'b1;
    step();
    chk("R1 after release", 32'(raw_e | raw_s | raw_p), 32'd0);

    // R2 set and hold, R9 single channel
    en[0] = '1; en[1] = '1; en[2] = '1; mask = 32'd1 << SB;
    ev[0] = 16'h8000;
    step();
    idle();
    step();
    step();
    chk("R2 end flag holds", 32'(raw_e), 32'h8000);
    chk("R9 only channel 15", 32'(chan_irq), 32'h8000);

    // R4 set and clear together, on a set and an unset flag
    ev[0] = 16'h8008; cl[0] = 16'h8008;
    step();
    chk("R4 set wins", 32'(raw_e), 32'h8008);
    idle();

    // R3 clear: zero bits leave flags alone, ones clear
    cl[0] = 16'h0008;
    step();
    chk("R3 partial clear", 32'(raw_e), 32'h8000);
    cl[0] = 16'hffff;
    step();
    idle();
    chk("R3 full clear", 32'(raw_e), 32'h0000);
    #1;
    chk("R7 idle pending", pend, 32'd0);

    // R6 disabled cause latched but quiet, R5 enable follows same cycle
    en[1] = '0;
    ev[1] = 16'h0020;
    step();
    idle();
    chk("R6 latched while disabled", 32'(raw_s), 32'h0020);
    chk("R6 no status while disabled", 32'(chan_irq), 32'h0000);
    en[1] = 16'h0020;
    #1;
    chk("R5 enable takes effect", 32'(chan_irq), 32'h0020);

    // R8 only bit 25 of the mask matters
    mask = ~(32'd1 << SB);
    #1;
    chk("R8 other mask bits ignored", 32'(cpu_irq), 32'd0);
    chk("R7 bit 25 pending", pend, 32'd1 << SB);
    mask = 32'd1 << SB;
    #1;
    chk("R8 mask bit passes", 32'(cpu_irq), 32'd1);
    step();

    // random mix
    for (int i = 0; i < 600; i++) begin
      for (int c = 0; c < 3; c++) begin
        ev[c] = NCH'($urandom & $urandom & $urandom);
        cl[c] = NCH'($urandom & $urandom);
        en[c] = NCH'($urandom);
      end
      mask = $urandom;
      step();
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule